// File: doc/BRIEF.md
# Header Clock-Ratio Detector

This block sits beside a configuration-image stream and watches its opening words. Each image arrives as 32-bit words with a valid qualifier and an end-of-image marker. The block counts accepted words from zero. It takes an encryption indication from one fixed header word and a compression indication from a later fixed header word. From those two flags and a selected port width (16 or 32 bits) it forms a 2-bit code for the clock-to-data ratio that the downstream loader must use.

A start pulse arms the block for a new image. Once the later header word has been accepted, a one-cycle result strobe is raised, and the code and both flags hold until the next start. If the image ends before that word arrives, a one-cycle error strobe is raised instead and no code is produced. The block never alters or forwards the data.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, ratio_o, encrypted_o, compressed_o, result_valid_o and short_err_o are all 0 and the word count starts at index 0.
- R2: The word accepted at index 69 (counting from 0) sets encrypted_o to 1 when its bits [3:2] are not both zero, and to 0 otherwise. encrypted_o shows this value from the cycle after that word is accepted.
- R3: The word accepted at index 229 sets compressed_o to 1 when its bit 1 is 0, and to 0 when bit 1 is 1.
- R4: result_valid_o is high for exactly one cycle, the cycle after the word at index 229 is accepted. ratio_o and both flags are valid in that cycle and hold until the next start pulse.
- R5: The ratio codes are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. width_sel_i = 1 selects 32 bits and 0 selects 16 bits, sampled in the cycle word 229 is accepted. A compressed image gets code 2, and an image that is encrypted but not compressed gets code 1. Each of these codes is one higher at 32 bits.
- R6: An image that is neither encrypted nor compressed gets code 0 at either width.
- R7: If an accepted word carries word_last_i at an index below 229, short_err_o is high for exactly the next cycle, result_valid_o stays low and ratio_o stays 0. A last marker on word 229 itself is a normal result and raises no error.
- R8: A start pulse clears the word count, both flags and ratio_o. In the following cycle all outputs read 0.
- R9: Words after index 229 are ignored until the next start pulse, including a last marker on them. They raise no strobe and leave ratio_o and the flags unchanged.
- R10: Cycles with word_valid_i low do not advance the count. A word presented in the same cycle as the start pulse is dropped and not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-image pulse; clears count and flags |
| word_valid_i | input | 1 | Qualifies word_i and word_last_i |
| word_i | input | 32 | Image word |
| word_last_i | input | 1 | Marks the final word of the image |
| width_sel_i | input | 1 | Port width: 1 = 32-bit, 0 = 16-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| encrypted_o | output | 1 | Captured encryption flag |
| compressed_o | output | 1 | Captured compression flag |
| result_valid_o | output | 1 | One-cycle result strobe |
| short_err_o | output | 1 | One-cycle strobe for an image shorter than the header |

## Verification
Some properties are checked on every cycle: both strobes last a single cycle and never coincide, and each strobe follows an accepted word. A start pulse always leaves every output cleared. ratio_o changes only alongside a result strobe or after a start, and an image with neither flag always yields code 0. Other behaviour can only be shown by the bench's image scenarios. These cover which word positions and bit fields feed the flags, the full width-by-flag ratio table, and the exact cycle of each strobe relative to word 229 or to an early last marker. They also cover that idle cycles, the word that shares a cycle with a start pulse, and trailing words are all left out of the count.

// File: rtl/hrd_pkg.sv
package hrd_pkg;

    localparam logic [1:0] RATIO_X1 = 2'd0;
    localparam logic [1:0] RATIO_X2 = 2'd1;
    localparam logic [1:0] RATIO_X4 = 2'd2;
    localparam logic [1:0] RATIO_X8 = 2'd3;

    // Bit positions inside the two header words
    localparam int unsigned ENC_FIELD_LO = 2;
    localparam int unsigned ENC_FIELD_HI = 3;
    localparam int unsigned CMP_FLAG_BIT = 1;

    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_CLOSED  = 1'b1
    } hrd_state_e;

    typedef struct packed {
        logic [1:0] ratio;
        logic       strobe_ok;
        logic       strobe_err;
    } hrd_result_t;

    // Ratio from width and the two header flags
    function automatic logic [1:0] hrd_ratio(input logic wide, input logic enc, input logic cmp);
        logic [1:0] base;
        if (!enc && !cmp) begin
            return RATIO_X1;
        end
        base = cmp ? RATIO_X4 : RATIO_X2;
        return wide ? base + 2'd1 : base;
    endfunction

endpackage

// File: rtl/hrd_word_indexer.sv
module hrd_word_indexer
    import hrd_pkg::*;
#(
    parameter int unsigned FINAL_IDX = 229,
    parameter int unsigned CNT_W     = $clog2(FINAL_IDX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             valid,
    input  logic             last,
    output logic             accept,
    output logic [CNT_W-1:0] idx,
    output logic             hit_final,
    output logic             short_end
);

    localparam logic [CNT_W-1:0] FINAL_CNT = CNT_W'(FINAL_IDX);

    hrd_state_e       state_q;
    logic [CNT_W-1:0] idx_q;

    assign accept    = valid && !start && (state_q == ST_COLLECT);
    assign idx       = idx_q;
    assign hit_final = accept && (idx_q == FINAL_CNT);
    assign short_end = accept && last && (idx_q != FINAL_CNT);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state_q <= ST_COLLECT;
            idx_q   <= '0;
        end else if (accept) begin
            if (hit_final || last) begin
                state_q <= ST_CLOSED;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hrd_flag_capture.sv
module hrd_flag_capture
    import hrd_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned ENC_IDX = 69,
    parameter int unsigned CMP_IDX = 229,
    parameter int unsigned CNT_W   = $clog2(CMP_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              accept,
    input  logic [CNT_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output logic              enc_q,
    output logic              cmp_q,
    output logic              cmp_now
);

    logic enc_now;
    logic unused_word_bits;

    assign enc_now = |word[ENC_FIELD_HI:ENC_FIELD_LO];
    assign cmp_now = !word[CMP_FLAG_BIT];
    assign unused_word_bits = ^{word[WORD_W-1:ENC_FIELD_HI+1], word[0]};

    always_ff @(posedge clk) begin
        if (rst || start) begin
            enc_q <= 1'b0;
            cmp_q <= 1'b0;
        end else if (accept) begin
            if (idx == CNT_W'(ENC_IDX)) begin
                enc_q <= enc_now;
            end
            if (idx == CNT_W'(CMP_IDX)) begin
                cmp_q <= cmp_now;
            end
        end
    end

endmodule

// File: rtl/hrd_result_stage.sv
module hrd_result_stage
    import hrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        hit_final,
    input  logic        short_end,
    input  logic        wide,
    input  logic        enc_q,
    input  logic        cmp_now,
    output hrd_result_t res_q
);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            res_q <= '0;
        end else begin
            res_q.strobe_ok  <= hit_final;
            res_q.strobe_err <= short_end;
            if (hit_final) begin
                res_q.ratio <= hrd_ratio(wide, enc_q, cmp_now);
            end
        end
    end

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
    import hrd_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned ENC_IDX = 69,
    parameter int unsigned CMP_IDX = 229
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_last_i,
    input  logic              width_sel_i,
    output logic [1:0]        ratio_o,
    output logic              encrypted_o,
    output logic              compressed_o,
    output logic              result_valid_o,
    output logic              short_err_o
);

    localparam int unsigned CNT_W = $clog2(CMP_IDX + 1);

    logic             accept;
    logic [CNT_W-1:0] idx;
    logic             hit_final;
    logic             short_end;
    logic             enc_q;
    logic             cmp_q;
    logic             cmp_now;
    hrd_result_t      res_q;

    hrd_word_indexer #(
        .FINAL_IDX (CMP_IDX),
        .CNT_W     (CNT_W)
    ) u_index (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .valid     (word_valid_i),
        .last      (word_last_i),
        .accept    (accept),
        .idx       (idx),
        .hit_final (hit_final),
        .short_end (short_end)
    );

    hrd_flag_capture #(
        .WORD_W  (WORD_W),
        .ENC_IDX (ENC_IDX),
        .CMP_IDX (CMP_IDX),
        .CNT_W   (CNT_W)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .accept  (accept),
        .idx     (idx),
        .word    (word_i),
        .enc_q   (enc_q),
        .cmp_q   (cmp_q),
        .cmp_now (cmp_now)
    );

    hrd_result_stage u_result (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .hit_final (hit_final),
        .short_end (short_end),
        .wide      (width_sel_i),
        .enc_q     (enc_q),
        .cmp_now   (cmp_now),
        .res_q     (res_q)
    );

    assign ratio_o        = res_q.ratio;
    assign result_valid_o = res_q.strobe_ok;
    assign short_err_o    = res_q.strobe_err;
    assign encrypted_o    = enc_q;
    assign compressed_o   = cmp_q;

endmodule

// File: rtl/hrd_checker.sv
module hrd_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       word_valid_i,
    input logic [1:0] ratio_o,
    input logic       encrypted_o,
    input logic       compressed_o,
    input logic       result_valid_o,
    input logic       short_err_o
);

    p_result_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o);

    p_result_after_word_r4: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> ($past(word_valid_i) && !$past(start_i)));

    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        short_err_o |=> !short_err_o);

    p_err_after_word_r7: assert property (@(posedge clk) disable iff (rst)
        short_err_o |-> ($past(word_valid_i) && !$past(start_i)));

    p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(result_valid_o && short_err_o));

    p_plain_is_x1_r6: assert property (@(posedge clk) disable iff (rst)
        (result_valid_o && !encrypted_o && !compressed_o) |-> (ratio_o == 2'd0));

    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (ratio_o == 2'd0 && !encrypted_o && !compressed_o
                     && !result_valid_o && !short_err_o));

    p_ratio_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (ratio_o != $past(ratio_o)) |-> (result_valid_o || $past(start_i)));

endmodule

bind hdr_ratio_detect hrd_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .word_valid_i   (word_valid_i),
    .ratio_o        (ratio_o),
    .encrypted_o    (encrypted_o),
    .compressed_o   (compressed_o),
    .result_valid_o (result_valid_o),
    .short_err_o    (short_err_o)
);

// File: tb/hdr_ratio_detect_tb.sv
`timescale 1ns/1ps
module hdr_ratio_detect_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        word_last_i = 1'b0;
    logic        width_sel_i = 1'b0;
    logic [1:0]  ratio_o;
    logic        encrypted_o;
    logic        compressed_o;
    logic        result_valid_o;
    logic        short_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [31:0] FILLER = 32'hA5A5_0002;

    typedef struct {
        bit       is_err;
        bit [1:0] ratio;
        bit       enc;
        bit       cmp;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    hdr_ratio_detect u_dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .word_valid_i   (word_valid_i),
        .word_i         (word_i),
        .word_last_i    (word_last_i),
        .width_sel_i    (width_sel_i),
        .ratio_o        (ratio_o),
        .encrypted_o    (encrypted_o),
        .compressed_o   (compressed_o),
        .result_valid_o (result_valid_o),
        .short_err_o    (short_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && (result_valid_o || short_err_o)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected strobe", int'(result_valid_o), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_err) begin
                    chk(short_err_o && !result_valid_o, "R7 error strobe", int'(short_err_o), 1);
                    chk(ratio_o == 2'd0, "R7 no ratio", int'(ratio_o), 0);
                end else begin
                    chk(result_valid_o && !short_err_o, "R4 result strobe", int'(result_valid_o), 1);
                    chk(ratio_o == e.ratio, "R5 ratio code", int'(ratio_o), int'(e.ratio));
                    chk(encrypted_o == e.enc, "R2 encrypted flag", int'(encrypted_o), int'(e.enc));
                    chk(compressed_o == e.cmp, "R3 compressed flag", int'(compressed_o), int'(e.cmp));
                end
            end
        end
    end

    // Driver: one image; pushes the expected outcome
    task automatic send_image(input int n, input logic [31:0] w69, input logic [31:0] w229,
                              input logic wd, input bit gaps, input bit start_word);
        bit       e;
        bit       c;
        bit [1:0] r;
        exp_t     item;
        e = (w69[3:2] != 2'b00);
        c = !w229[1];
        if (!e && !c) r = 2'd0;
        else r = (c ? 2'd2 : 2'd1) + (wd ? 2'd1 : 2'd0);

        @(negedge clk);
        start_i      = 1'b1;
        width_sel_i  = wd;
        word_valid_i = start_word;
        word_i       = 32'h0000_0000;
        word_last_i  = 1'b0;
        @(negedge clk);
        start_i      = 1'b0;
        word_valid_i = 1'b0;
        chk(!encrypted_o && !compressed_o && ratio_o == 2'd0 && !result_valid_o,
            "R8 start clears", int'({ratio_o, encrypted_o, compressed_o}), 0);

        item.is_err = (n < 230);
        item.ratio  = (n < 230) ? 2'd0 : r;
        item.enc    = e;
        item.cmp    = c;
        if (n > 0) sb_q.push_back(item);

        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 0)) begin
                word_valid_i = 1'b0;
                word_i       = 32'h0000_000C;
                word_last_i  = 1'b1;
                @(negedge clk);
            end
            word_valid_i = 1'b1;
            word_i       = (i == 69) ? w69 : ((i == 229) ? w229 : FILLER);
            word_last_i  = (i == n - 1);
            @(negedge clk);
            word_valid_i = 1'b0;
            word_last_i  = 1'b0;
            if (i == 69) chk(encrypted_o == e, "R2 flag timing", int'(encrypted_o), int'(e));
            if (i == 229) chk(result_valid_o == 1'b1, "R4 strobe cycle", int'(result_valid_o), 1);
            if (i == 230) chk(result_valid_o == 1'b0, "R4 single pulse", int'(result_valid_o), 0);
            if (i == n - 1 && n < 230)
                chk(short_err_o == 1'b1, "R7 error cycle", int'(short_err_o), 1);
            if (i == n - 1 && n >= 230)
                chk(short_err_o == 1'b0, "R9 trailing last ignored", int'(short_err_o), 0);
        end
        @(negedge clk);
        if (n >= 230) begin
            chk(ratio_o == r && encrypted_o == e && compressed_o == c, "R9 result holds",
                int'({ratio_o, encrypted_o, compressed_o}), int'({r, e, c}));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ratio_o == 2'd0 && !encrypted_o && !compressed_o && !result_valid_o && !short_err_o,
            "R1 reset state", int'({ratio_o, encrypted_o, compressed_o, result_valid_o, short_err_o}), 0);

        // R6 plain images at both widths
        send_image(230, 32'h0000_0003, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        send_image(230, 32'hFFFF_FFF3, 32'h0000_0002, 1'b1, 1'b0, 1'b0);
        // R5 encrypted only
        send_image(230, 32'h0000_0004, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
        send_image(230, 32'h0000_0008, 32'h0000_0002, 1'b1, 1'b0, 1'b0);
        // R3 R5 compressed only
        send_image(230, 32'h0000_0000, 32'hFFFF_FFFD, 1'b0, 1'b0, 1'b0);
        send_image(230, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        // R5 both flags
        send_image(230, 32'h0000_000C, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
        send_image(230, 32'h0000_000C, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
        // R7 short images
        send_image(100, 32'h0000_000C, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        send_image(229, 32'h0000_0004, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
        // R9 trailing words ignored
        send_image(300, 32'h0000_0004, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
        // R10 idle cycles and a word alongside the start pulse
        send_image(230, 32'h0000_0008, 32'h0000_0000, 1'b0, 1'b1, 1'b0);
        send_image(230, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule